// File: doc/BRIEF.md
# Ping-pong buffer sample fetcher

This block keeps a converter's data register fed from memory with no processor involvement per sample. It holds two descriptors, each a base address and a sample count. A request from the converter, raised after each finished conversion, makes the engine read the next word of the active buffer and write it to the converter. That write is what lowers the request.

When the last word of the active buffer has been written, the engine moves to the other buffer in that same cycle and pulses a done interrupt that names the finished buffer. The finished buffer is disarmed. Software refills it and arms it again through the configuration port, while the other buffer is being played. If the engine reaches a buffer that has not been armed, it stops and raises an underrun flag. Arming either buffer while stopped restarts the engine at that buffer.

Top module: `pingpong_fetcher`

## Requirements
- R1: After reset, mem_rd_en, dac_wr_en, irq_done and underrun are all 0, and the engine is stopped: a request produces neither a read nor a write until a buffer is armed.
- R2: While running, a high dac_req with no write pending drives mem_rd_en high in that same cycle, at address base + offset of the active buffer.
- R3: Exactly one cycle after each read, dac_wr_en is high for one cycle and dac_wr_data carries the word the memory returned for that read. There is no write without a read.
- R4: Successive requests on one buffer read base, base+1, base+2 and so on. The offset goes up by one on each write.
- R5: On the write of the last word of a buffer, irq_done is high for that cycle and irq_buf gives the finished buffer (0 or 1). If the other buffer is armed, the next request reads from its base.
- R6: A finished buffer is disarmed. If the other buffer is not armed at the hand-over, underrun goes high in the next cycle and the engine stops. Later requests cause no read and no write.
- R7: A configuration write (cfg_wr_en, cfg_buf, cfg_base, cfg_len_m1) arms the chosen buffer. If the engine is stopped, it restarts at that buffer from offset 0 and underrun returns to 0.
- R8: A configuration write aimed at the buffer that is currently active while running has no effect on its address or length.
- R9: A configuration write that arms the other buffer in the same cycle as the last-word write is accepted. The engine hands over to that buffer and underrun stays 0.
- R10: cfg_len_m1 holds the sample count minus one. Counts of 1 and 1024 (cfg_len_m1 = 0 and 1023) give exactly that many words before the hand-over.
- R11: No read is issued in a cycle in which a write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dac_req | input | 1 | Converter wants its next sample (level, lowered by the write) |
| dac_wr_en | output | 1 | Write strobe into the converter data register |
| dac_wr_data | output | DATA_W | Sample written to the converter |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read word address |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after mem_rd_en |
| cfg_wr_en | input | 1 | Descriptor write and arm strobe |
| cfg_buf | input | 1 | Buffer selected by the descriptor write |
| cfg_base | input | ADDR_W | Base word address to store |
| cfg_len_m1 | input | LEN_W | Sample count minus one to store |
| irq_done | output | 1 | One-cycle pulse when a buffer is finished |
| irq_buf | output | 1 | Which buffer finished, valid with irq_done |
| underrun | output | 1 | Engine stopped on a buffer that was not armed |

## Verification
Two things can happen in the same clock edge: the hand-over that disarms the finished buffer, and software arming a buffer. The bench drives a configuration write during the very cycle in which the last word of buffer 0 is written. It arms buffer 1 in that cycle and then checks three things: no underrun, the next read at buffer 1's base, and the full 1024-word run that follows. It also writes to the active buffer in mid-run. The bench then judges from the addresses of the following reads, and from the place of the next interrupt, that the write was dropped.

// File: rtl/pf_pkg.sv
package pf_pkg;

  localparam int unsigned PF_NBUF = 2;

  // True when the current offset is the final word of a buffer.
  function automatic logic pf_at_end(input int unsigned offset, input int unsigned last_off);
    return offset == last_off;
  endfunction

endpackage

// File: rtl/pf_desc.sv
module pf_desc #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_set,
  input  logic              arm_clr,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [LEN_W-1:0]  len_in,
  output logic [ADDR_W-1:0] base_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              armed_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      len_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (arm_set) begin
        base_q <= base_in;
        len_q  <= len_in;
      end
      if (arm_set)      armed_q <= 1'b1;
      else if (arm_clr) armed_q <= 1'b0;
    end
  end

  // R8
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_set |=> $stable(base_q) && $stable(len_q));

endmodule

// File: rtl/pf_seq.sv
module pf_seq
  import pf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dac_req,
  input  logic                       cfg_wr_en,
  input  logic                       cfg_buf,
  input  logic [1:0][ADDR_W-1:0]     d_base,
  input  logic [1:0][LEN_W-1:0]      d_len,
  input  logic [1:0]                 d_armed,
  output logic [1:0]                 arm_set,
  output logic [1:0]                 arm_clr,
  output logic                       mem_rd_en,
  output logic [ADDR_W-1:0]          mem_rd_addr,
  output logic                       dac_wr_en,
  output logic                       irq_done,
  output logic                       irq_buf,
  output logic                       underrun
);

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [LEN_W-1:0] off);
    return b + ADDR_W'(off);
  endfunction

  logic             running_q, active_q, pend_q, last_q, underrun_q;
  logic [LEN_W-1:0] ptr_q;
  logic             other_buf, cfg_accept, rd_go, handover, alt_ready, rd_last;

  assign other_buf  = ~active_q;
  assign cfg_accept = cfg_wr_en && !(running_q && (cfg_buf == active_q));
  assign rd_go      = running_q && dac_req && !pend_q;
  assign handover   = pend_q && last_q;
  assign rd_last    = pf_at_end(32'(ptr_q), 32'(d_len[active_q]));

  always_comb begin
    for (int b = 0; b < PF_NBUF; b++) begin
      arm_set[b] = cfg_accept && (cfg_buf == b[0]);
      arm_clr[b] = handover && (active_q == b[0]);
    end
  end

  assign alt_ready   = d_armed[other_buf] || arm_set[other_buf];
  assign mem_rd_en   = rd_go;
  assign mem_rd_addr = word_addr(d_base[active_q], ptr_q);
  assign dac_wr_en   = pend_q;
  assign irq_done    = handover;
  assign irq_buf     = active_q;
  assign underrun    = underrun_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q  <= 1'b0;
      active_q   <= 1'b0;
      pend_q     <= 1'b0;
      last_q     <= 1'b0;
      underrun_q <= 1'b0;
      ptr_q      <= '0;
    end else begin
      pend_q <= rd_go;
      last_q <= rd_go && rd_last;
      if (handover) begin
        ptr_q    <= '0;
        active_q <= other_buf;
        if (!alt_ready) begin
          running_q  <= 1'b0;
          underrun_q <= 1'b1;
        end
      end else if (pend_q) begin
        ptr_q <= ptr_q + 1'b1;
      end else if (!running_q && cfg_accept) begin
        running_q  <= 1'b1;
        active_q   <= cfg_buf;
        ptr_q      <= '0;
        underrun_q <= 1'b0;
      end
    end
  end

  // R5
  handover_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handover && alt_ready |=> running_q && (active_q != $past(active_q)) && (ptr_q == '0));

  // R6
  underrun_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_q |-> !mem_rd_en && !dac_wr_en);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !last_q |=> ptr_q == $past(ptr_q) + 1'b1);

  // R10
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ptr_q <= d_len[active_q]);

  // R9
  late_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handover && arm_set[other_buf] |=> !underrun_q);

endmodule

// File: rtl/pingpong_fetcher.sv
module pingpong_fetcher
  import pf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 12,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dac_req,
  output logic              dac_wr_en,
  output logic [DATA_W-1:0] dac_wr_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              cfg_wr_en,
  input  logic              cfg_buf,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  output logic              irq_done,
  output logic              irq_buf,
  output logic              underrun
);

  logic [1:0][ADDR_W-1:0] d_base;
  logic [1:0][LEN_W-1:0]  d_len;
  logic [1:0]             d_armed;
  logic [1:0]             arm_set, arm_clr;

  for (genvar g = 0; g < PF_NBUF; g++) begin : g_desc
    pf_desc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_desc (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_set (arm_set[g]),
      .arm_clr (arm_clr[g]),
      .base_in (cfg_base),
      .len_in  (cfg_len_m1),
      .base_q  (d_base[g]),
      .len_q   (d_len[g]),
      .armed_q (d_armed[g])
    );
  end

  pf_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .dac_req     (dac_req),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_buf     (cfg_buf),
    .d_base      (d_base),
    .d_len       (d_len),
    .d_armed     (d_armed),
    .arm_set     (arm_set),
    .arm_clr     (arm_clr),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .dac_wr_en   (dac_wr_en),
    .irq_done    (irq_done),
    .irq_buf     (irq_buf),
    .underrun    (underrun)
  );

  assign dac_wr_data = mem_rd_data;

  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr_en |-> $past(mem_rd_en));

  // R11
  rd_excl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !dac_wr_en);

  // R5
  irq_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> dac_wr_en);

endmodule

// File: tb/tb_pingpong_fetcher.sv
`timescale 1ns/1ps
module tb_pingpong_fetcher;

  localparam int AW = 16;
  localparam int DW = 12;
  localparam int LW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dac_req, cfg_wr_en, cfg_buf;
  logic [AW-1:0] cfg_base;
  logic [LW-1:0] cfg_len_m1;
  logic [DW-1:0] mem_rd_data;
  logic          dac_wr_en, mem_rd_en, irq_done, irq_buf, underrun;
  logic [DW-1:0] dac_wr_data;
  logic [AW-1:0] mem_rd_addr;

  always #4 clk = ~clk;

  pingpong_fetcher #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .dac_req(dac_req), .dac_wr_en(dac_wr_en),
    .dac_wr_data(dac_wr_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .cfg_wr_en(cfg_wr_en), .cfg_buf(cfg_buf),
    .cfg_base(cfg_base), .cfg_len_m1(cfg_len_m1), .irq_done(irq_done),
    .irq_buf(irq_buf), .underrun(underrun));

  function automatic int word_at(input int a);
    return (a * 13 + 5) % 4096;
  endfunction

  // memory model: one-cycle read latency
  always_ff @(posedge clk)
    if (mem_rd_en) mem_rd_data <= DW'(word_at(int'(mem_rd_addr)));

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct { int data; int irq; int bsel; } wexp_t;
  int    rdq[$];
  wexp_t wrq[$];

  // reference model of the descriptors
  int m_base[2], m_cnt[2];
  bit m_armed[2];
  bit m_run = 0, m_und = 0;
  int m_act = 0, m_ptr = 0;

  function automatic void model_arm(input int b, input int base, input int cnt);
    if (m_run && b == m_act) return;          // R8
    m_base[b] = base; m_cnt[b] = cnt; m_armed[b] = 1;
    if (!m_run) begin m_run = 1; m_act = b; m_ptr = 0; m_und = 0; end  // R7
  endfunction

  // monitor
  always begin
    @(negedge clk); #2;
    if (rst_n) begin
      if (mem_rd_en) begin
        if (rdq.size() == 0) chk("R6 unexpected read", 1, 0);
        else chk("R2 R4 read address", int'(mem_rd_addr), rdq.pop_front());
      end
      if (dac_wr_en) begin
        if (wrq.size() == 0) chk("R3 unexpected write", 1, 0);
        else begin
          wexp_t e;
          e = wrq.pop_front();
          chk("R3 write data", int'(dac_wr_data), e.data);
          chk("R5 irq_done", int'(irq_done), e.irq);
          if (e.irq != 0) chk("R5 irq_buf", int'(irq_buf), e.bsel);
        end
      end else if (irq_done) chk("R5 irq without write", 1, 0);
    end
  end

  task automatic arm(input int b, input int base, input int cnt);
    @(negedge clk);
    cfg_wr_en = 1; cfg_buf = b[0]; cfg_base = AW'(base); cfg_len_m1 = LW'(cnt - 1);
    model_arm(b, base, cnt);
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic sample(input bit co = 0, input int cb = 0, input int cbase = 0, input int ccnt = 1);
    bit srv, got;
    srv = m_run;
    if (srv) begin
      int a;
      wexp_t e;
      bit last;
      a = (m_base[m_act] + m_ptr) % 65536;
      last = (m_ptr == m_cnt[m_act] - 1);
      rdq.push_back(a);
      e.data = word_at(a); e.irq = last; e.bsel = m_act;
      wrq.push_back(e);
      if (co) model_arm(cb, cbase, ccnt);
      if (last) begin
        m_armed[m_act] = 0;
        m_act = 1 - m_act; m_ptr = 0;
        if (!m_armed[m_act]) begin m_run = 0; m_und = 1; end
      end else m_ptr++;
    end
    @(negedge clk);
    dac_req = 1; got = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (dac_wr_en) begin
        got = 1;
        if (co) begin
          cfg_wr_en = 1; cfg_buf = cb[0]; cfg_base = AW'(cbase); cfg_len_m1 = LW'(ccnt - 1);
        end
        break;
      end
    end
    dac_req = 0;
    if (co && got) begin @(negedge clk); cfg_wr_en = 0; end
    chk("R2 request served", int'(got), int'(srv));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 0; dac_req = 0; cfg_wr_en = 0; cfg_buf = 0; cfg_base = '0; cfg_len_m1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mem_rd_en after reset", int'(mem_rd_en), 0);
    chk("R1 dac_wr_en after reset", int'(dac_wr_en), 0);
    chk("R1 irq_done after reset", int'(irq_done), 0);
    chk("R1 underrun after reset", int'(underrun), 0);
    sample();                                 // R1: stopped, no service

    arm(0, 'h100, 3);
    arm(1, 'h200, 2);
    repeat (3) sample();                      // R4 R5 buffer 0 then hand-over
    repeat (2) sample();                      // buffer 1, buffer 0 not re-armed
    @(negedge clk);
    chk("R6 underrun raised", int'(underrun), 1);
    sample();                                 // R6: no read, no write
    chk("R6 underrun held", int'(underrun), 1);

    arm(1, 'h300, 1);                         // R7 restart at buffer 1
    chk("R7 underrun cleared", int'(underrun), 0);
    arm(0, 'h400, 2);
    sample();                                 // R10 count of one
    sample();                                 // buffer 0 word 0
    arm(0, 'h500, 5);                         // R8 ignored
    sample(1'b1, 1, 'h600, 1024);             // R9 arm in hand-over cycle
    @(negedge clk);
    chk("R9 no underrun", int'(underrun), 0);
    arm(0, 'h10, 2);
    repeat (1024) sample();                   // R10 count of 1024
    repeat (2) sample();
    @(negedge clk);
    chk("R6 underrun after final buffer", int'(underrun), 1);
    repeat (3) @(negedge clk);
    chk("R3 all reads seen", rdq.size(), 0);
    chk("R3 all writes seen", wrq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule